// File: doc/BRIEF.md
# Packed SIMD Saturating DSP Unit

This execution unit works on 32-bit operands. It reads each operand either as four unsigned bytes or as two signed 16-bit halves. It performs lane-wise add and subtract, with either wrap-around or clamping, and lane-wise shifts. It also computes fractional products in Q15 and Q31 format, where each signed value lies from -1 up to just below +1. Those products can be accumulated into, or subtracted from, one of four 64-bit accumulators that the unit keeps internally.

A sequencer presents an opcode, two operands, a saturation-mode bit and an accumulator index, and raises a valid strobe for one cycle. One cycle later the registered result appears, together with a one-cycle result-valid pulse. Accumulator contents are read back through two read opcodes, one for each 32-bit half. A sticky overflow flag records every clamp the unit applies. The flag stays set until the sequencer raises the clear input.

Top module: `simd_dsp_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `res` becomes 0, `res_valid` becomes 0, `ovf_sticky` becomes 0 and all four accumulators become 0.
- R2: An operation presented with `in_valid` high is reflected at the edge where it is sampled. `res_valid` is high for exactly the following cycle. While `in_valid` is low, `res` keeps its value.
- R3: Opcode 0 adds and opcode 1 subtracts each of the four unsigned byte lanes (lane k occupies bits 8k+7:8k). With `sat_mode`=0 the result wraps. With `sat_mode`=1 the result clamps to 0..255, and each clamp sets the overflow flag.
- R4: Opcode 2 adds and opcode 3 subtracts each of the two signed halfword lanes. With `sat_mode`=0 the result wraps. With `sat_mode`=1 the result clamps to -32768..32767 and sets the overflow flag.
- R5: Opcode 4 shifts each byte left and opcode 5 shifts each byte right (logical), by `opnd_b[2:0]`. Opcode 6 shifts each halfword left (logical) and opcode 7 shifts each halfword right (arithmetic), by `opnd_b[3:0]`. Shifts ignore `sat_mode` and never set the overflow flag.
- R6: Opcode 8 multiplies each halfword lane as Q15, giving the product shifted right by 15 with truncation. The case -1 x -1 gives 0x7FFF and sets the overflow flag.
- R7: Opcode 9 multiplies the full words as Q31, giving the product shifted right by 31. The case -1 x -1 gives 0x7FFFFFFF and sets the overflow flag.
- R8: Opcode 10 adds and opcode 11 subtracts the Q15 product of the low halves of the operands, doubled and sign-extended to 64 bits, to or from accumulator `acc_sel`. The case -1 x -1 contributes 0x7FFFFFFF and sets the overflow flag.
- R9: Opcode 12 adds and opcode 13 subtracts the doubled Q31 product of the operands to or from accumulator `acc_sel`. The case -1 x -1 contributes 0x7FFFFFFFFFFFFFFF and sets the overflow flag, whatever `sat_mode` is.
- R10: With `sat_mode`=1, an accumulation that overflows clamps to the signed 64-bit limit on the side of the overflow and sets the overflow flag. With `sat_mode`=0 it wraps and sets no flag.
- R11: Opcode 14 returns the low word and opcode 15 the high word of accumulator `acc_sel`. The four accumulate opcodes (10 to 13) leave `res` unchanged.
- R12: `ovf_sticky` stays set until `ovf_clr` is high at an edge. When an overflow occurs at the same edge as a clear, the flag is set.
- R13: While `in_valid` is low, no accumulator, `res` or `ovf_sticky` bit is set by the operands or opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Opcode (see requirements) |
| sat_mode | input | 1 | Clamp instead of wrap on add/subtract and accumulation |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand or shift amount |
| acc_sel | input | 2 | Accumulator index |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| res | output | 32 | Registered result |
| res_valid | output | 1 | One-cycle pulse after an accepted operation |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
The checker watches the protocol on every cycle. It covers the one-cycle valid pulse, the holding of the result while idle, and the hold and clear behaviour of the sticky flag. It also checks that the flag never sets without an operation and that accumulate opcodes leave the result untouched. It watches the Q15 corner case of -1 x -1 in both lanes as well. Lane arithmetic values are shown only by the bench's scenarios. These cover wrap versus clamp at both ends of each lane format, the shift amounts and sign fill, and truncation in the fractional products. The bench also reads back accumulators after clamping at the positive and negative limits, and after wrapping with saturation off.

// File: rtl/simd_dsp_pkg.sv
package simd_dsp_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 64;

    typedef enum logic [3:0] {
        OP_ADD_B   = 4'd0,
        OP_SUB_B   = 4'd1,
        OP_ADD_H   = 4'd2,
        OP_SUB_H   = 4'd3,
        OP_SHL_B   = 4'd4,
        OP_SHR_B   = 4'd5,
        OP_SHL_H   = 4'd6,
        OP_SRA_H   = 4'd7,
        OP_MUL_Q15 = 4'd8,
        OP_MUL_Q31 = 4'd9,
        OP_MAC_Q15 = 4'd10,
        OP_MSU_Q15 = 4'd11,
        OP_MAC_Q31 = 4'd12,
        OP_MSU_Q31 = 4'd13,
        OP_RD_LO   = 4'd14,
        OP_RD_HI   = 4'd15
    } dsp_op_e;

    typedef struct packed {
        logic              ovf;
        logic [BYTE_W-1:0] v;
    } lane8_t;

    typedef struct packed {
        logic              ovf;
        logic [HALF_W-1:0] v;
    } lane16_t;

    function automatic lane8_t u8_addsub(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] b,
                                         input logic sub, input logic sat);
        lane8_t r;
        logic [BYTE_W:0] s;
        s = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        r.v   = s[BYTE_W-1:0];
        r.ovf = 1'b0;
        if (sat && s[BYTE_W]) begin
            r.v   = sub ? '0 : '1;
            r.ovf = 1'b1;
        end
        return r;
    endfunction

    function automatic lane16_t s16_addsub(input logic [HALF_W-1:0] a,
                                           input logic [HALF_W-1:0] b,
                                           input logic sub, input logic sat);
        lane16_t r;
        logic [HALF_W:0] s;
        s = sub ? ({a[HALF_W-1], a} - {b[HALF_W-1], b})
                : ({a[HALF_W-1], a} + {b[HALF_W-1], b});
        r.v   = s[HALF_W-1:0];
        r.ovf = 1'b0;
        if (sat && (s[HALF_W] != s[HALF_W-1])) begin
            r.v   = s[HALF_W] ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}};
            r.ovf = 1'b1;
        end
        return r;
    endfunction

    function automatic logic is_accum_op(input dsp_op_e op);
        return (op == OP_MAC_Q15) || (op == OP_MSU_Q15) ||
               (op == OP_MAC_Q31) || (op == OP_MSU_Q31);
    endfunction

endpackage

// File: rtl/dsp_lane_alu.sv
module dsp_lane_alu
    import simd_dsp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  dsp_op_e        op,
    input  logic           sat,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           ovf
);
    localparam int NB = W / BYTE_W;
    localparam int NH = W / HALF_W;

    logic [W-1:0]  addsub_b, shl_b, shr_b, addsub_h, shl_h, sra_h;
    logic [NB-1:0] ovf_b;
    logic [NH-1:0] ovf_h;
    logic          sub_b, sub_h;

    assign sub_b = (op == OP_SUB_B);
    assign sub_h = (op == OP_SUB_H);

    for (genvar i = 0; i < NB; i++) begin : g_byte
        lane8_t r;
        assign r = u8_addsub(a[i*BYTE_W +: BYTE_W], b[i*BYTE_W +: BYTE_W], sub_b, sat);
        assign addsub_b[i*BYTE_W +: BYTE_W] = r.v;
        assign ovf_b[i]                     = r.ovf;
        assign shl_b[i*BYTE_W +: BYTE_W]    = a[i*BYTE_W +: BYTE_W] << b[2:0];
        assign shr_b[i*BYTE_W +: BYTE_W]    = a[i*BYTE_W +: BYTE_W] >> b[2:0];
    end

    for (genvar j = 0; j < NH; j++) begin : g_half
        lane16_t r;
        assign r = s16_addsub(a[j*HALF_W +: HALF_W], b[j*HALF_W +: HALF_W], sub_h, sat);
        assign addsub_h[j*HALF_W +: HALF_W] = r.v;
        assign ovf_h[j]                     = r.ovf;
        assign shl_h[j*HALF_W +: HALF_W]    = a[j*HALF_W +: HALF_W] << b[3:0];
        assign sra_h[j*HALF_W +: HALF_W]    = $signed(a[j*HALF_W +: HALF_W]) >>> b[3:0];
    end

    always_comb begin
        y   = '0;
        ovf = 1'b0;
        case (op)
            OP_ADD_B, OP_SUB_B: begin y = addsub_b; ovf = |ovf_b; end
            OP_ADD_H, OP_SUB_H: begin y = addsub_h; ovf = |ovf_h; end
            OP_SHL_B:           y = shl_b;
            OP_SHR_B:           y = shr_b;
            OP_SHL_H:           y = shl_h;
            OP_SRA_H:           y = sra_h;
            default:            y = '0;
        endcase
    end
endmodule

// File: rtl/dsp_frac_mul.sv
module dsp_frac_mul
    import simd_dsp_pkg::*;
(
    input  dsp_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   mul_y,
    output logic                mul_ovf,
    output logic [ACC_W-1:0]    mac_prod,
    output logic                mac_ovf
);
    localparam int NH = DATA_W / HALF_W;

    logic [2*HALF_W-1:0] p15 [NH];
    logic [NH-1:0]       sat15;
    logic [DATA_W-1:0]   y15;

    for (genvar h = 0; h < NH; h++) begin : g_q15
        logic unused_lsb;
        assign p15[h]   = $signed(a[h*HALF_W +: HALF_W]) * $signed(b[h*HALF_W +: HALF_W]);
        assign sat15[h] = (p15[h][2*HALF_W-1 -: 2] == 2'b01);
        assign y15[h*HALF_W +: HALF_W] = sat15[h] ? {1'b0, {(HALF_W-1){1'b1}}}
                                                  : p15[h][2*HALF_W-2 -: HALF_W];
        assign unused_lsb = ^p15[h][HALF_W-2:0];
    end

    logic [2*DATA_W-1:0] p31;
    logic                sat31;
    logic [DATA_W-1:0]   y31;
    logic [ACC_W-1:0]    prod31, prod15;

    assign p31   = $signed(a) * $signed(b);
    assign sat31 = (p31[2*DATA_W-1 -: 2] == 2'b01);
    assign y31   = sat31 ? {1'b0, {(DATA_W-1){1'b1}}} : p31[2*DATA_W-2 -: DATA_W];

    assign prod31 = sat31 ? {1'b0, {(ACC_W-1){1'b1}}} : {p31[2*DATA_W-2:0], 1'b0};
    assign prod15 = sat15[0] ? {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}}
                             : {{(ACC_W-2*HALF_W-1){p15[0][2*HALF_W-1]}}, p15[0], 1'b0};

    always_comb begin
        if (op == OP_MUL_Q31) begin
            mul_y   = y31;
            mul_ovf = sat31;
        end else begin
            mul_y   = y15;
            mul_ovf = |sat15;
        end
        if ((op == OP_MAC_Q31) || (op == OP_MSU_Q31)) begin
            mac_prod = prod31;
            mac_ovf  = sat31;
        end else begin
            mac_prod = prod15;
            mac_ovf  = sat15[0];
        end
    end
endmodule

// File: rtl/dsp_acc_bank.sv
module dsp_acc_bank
    import simd_dsp_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = $clog2(NUM_ACC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_en,
    input  logic               do_sub,
    input  logic               sat,
    input  logic [SEL_W-1:0]   sel,
    input  logic [ACC_W-1:0]   prod,
    output logic [ACC_W-1:0]   rd_data,
    output logic               acc_ovf
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_q [NUM_ACC];
    logic [ACC_W-1:0] cur, sum, nxt;
    logic             ovf_raw;

    assign cur     = acc_q[sel];
    assign rd_data = cur;

    always_comb begin
        sum = do_sub ? (cur - prod) : (cur + prod);
        if (do_sub)
            ovf_raw = (cur[ACC_W-1] != prod[ACC_W-1]) && (sum[ACC_W-1] != cur[ACC_W-1]);
        else
            ovf_raw = (cur[ACC_W-1] == prod[ACC_W-1]) && (sum[ACC_W-1] != cur[ACC_W-1]);
        nxt     = sum;
        acc_ovf = 1'b0;
        if (sat && ovf_raw) begin
            nxt     = cur[ACC_W-1] ? ACC_MIN : ACC_MAX;
            acc_ovf = 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)
                acc_q[k] <= '0;
            else if (upd_en && (sel == SEL_W'(k)))
                acc_q[k] <= nxt;
        end
    end
endmodule

// File: rtl/simd_dsp_unit.sv
module simd_dsp_unit
    import simd_dsp_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = $clog2(NUM_ACC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         op,
    input  logic               sat_mode,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [SEL_W-1:0]   acc_sel,
    input  logic               ovf_clr,
    output logic [DATA_W-1:0]  res,
    output logic               res_valid,
    output logic               ovf_sticky
);
    dsp_op_e           op_e;
    logic [DATA_W-1:0] alu_y, mul_y, nxt_res;
    logic              alu_ovf, mul_ovf, mac_ovf, acc_ovf, ev_ovf;
    logic [ACC_W-1:0]  mac_prod, acc_rd;
    logic              accum, upd_en, do_sub;

    assign op_e   = dsp_op_e'(op);
    assign accum  = is_accum_op(op_e);
    assign upd_en = in_valid && accum;
    assign do_sub = (op_e == OP_MSU_Q15) || (op_e == OP_MSU_Q31);

    dsp_lane_alu #(.W(DATA_W)) u_alu (
        .op(op_e), .sat(sat_mode), .a(opnd_a), .b(opnd_b),
        .y(alu_y), .ovf(alu_ovf)
    );

    dsp_frac_mul u_mul (
        .op(op_e), .a(opnd_a), .b(opnd_b),
        .mul_y(mul_y), .mul_ovf(mul_ovf),
        .mac_prod(mac_prod), .mac_ovf(mac_ovf)
    );

    dsp_acc_bank #(.NUM_ACC(NUM_ACC)) u_acc (
        .clk(clk), .rst(rst), .upd_en(upd_en), .do_sub(do_sub),
        .sat(sat_mode), .sel(acc_sel), .prod(mac_prod),
        .rd_data(acc_rd), .acc_ovf(acc_ovf)
    );

    always_comb begin
        nxt_res = alu_y;
        ev_ovf  = alu_ovf;
        case (op_e)
            OP_MUL_Q15, OP_MUL_Q31: begin nxt_res = mul_y; ev_ovf = mul_ovf; end
            OP_MAC_Q15, OP_MSU_Q15,
            OP_MAC_Q31, OP_MSU_Q31: begin nxt_res = res; ev_ovf = mac_ovf | acc_ovf; end
            OP_RD_LO:               begin nxt_res = acc_rd[DATA_W-1:0]; ev_ovf = 1'b0; end
            OP_RD_HI:               begin nxt_res = acc_rd[ACC_W-1 -: DATA_W]; ev_ovf = 1'b0; end
            default:                ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res        <= '0;
            res_valid  <= 1'b0;
            ovf_sticky <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid)
                res <= nxt_res;
            if (in_valid && ev_ovf)
                ovf_sticky <= 1'b1;
            else if (ovf_clr)
                ovf_sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/simd_dsp_unit_chk.sv
module simd_dsp_unit_chk
    import simd_dsp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [3:0]         op,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b,
    input logic               ovf_clr,
    input logic [DATA_W-1:0]  res,
    input logic               res_valid,
    input logic               ovf_sticky
);
    logic accum_req;
    assign accum_req = (op == OP_MAC_Q15) || (op == OP_MSU_Q15) ||
                       (op == OP_MAC_Q31) || (op == OP_MSU_Q31);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (res == '0 && !res_valid && !ovf_sticky));

    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    a_r2_res_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res));

    a_r11_accum_keeps_res: assert property (@(posedge clk) disable iff (rst)
        (in_valid && accum_req) |=> $stable(res));

    a_r12_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !ovf_clr) |=> ovf_sticky);

    a_r12_clear_alone: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !in_valid) |=> !ovf_sticky);

    a_r13_no_set_idle: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !ovf_sticky) |=> !ovf_sticky);

    a_r6_q15_minus_one: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MUL_Q15 && opnd_a == 32'h8000_8000 && opnd_b == 32'h8000_8000)
        |=> (res == 32'h7FFF_7FFF && ovf_sticky));
endmodule

bind simd_dsp_unit simd_dsp_unit_chk chk_i (.*);

// File: tb/simd_dsp_unit_tb_top.sv
`timescale 1ns/1ps
module simd_dsp_unit_tb_top;
    import simd_dsp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        sat_mode = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  acc_sel = '0;
    logic        ovf_clr = 1'b0;
    logic [31:0] res;
    logic        res_valid;
    logic        ovf_sticky;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    simd_dsp_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .sat_mode(sat_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_sel(acc_sel), .ovf_clr(ovf_clr),
        .res(res), .res_valid(res_valid), .ovf_sticky(ovf_sticky)
    );

    // {op[3:0], sat, a[31:0], b[31:0], expected res[31:0], expected sticky}
    localparam int NV = 16;
    localparam logic [101:0] VEC [NV] = '{
        {4'd0,  1'b0, 32'h10F0_80FF, 32'h0120_8001, 32'h1110_0000, 1'b0},
        {4'd0,  1'b1, 32'h10F0_80FF, 32'h0120_8001, 32'h11FF_FFFF, 1'b1},
        {4'd1,  1'b0, 32'h0510_0080, 32'h0620_0001, 32'hFFF0_007F, 1'b0},
        {4'd1,  1'b1, 32'h0510_0080, 32'h0620_0001, 32'h0000_007F, 1'b1},
        {4'd2,  1'b0, 32'h7FFF_8000, 32'h0001_FFFF, 32'h8000_7FFF, 1'b0},
        {4'd2,  1'b1, 32'h7FFF_8000, 32'h0001_FFFF, 32'h7FFF_8000, 1'b1},
        {4'd3,  1'b1, 32'h8000_0005, 32'h0001_0003, 32'h8000_0002, 1'b1},
        {4'd3,  1'b1, 32'h1234_0100, 32'h0234_0200, 32'h1000_FF00, 1'b0},
        {4'd4,  1'b1, 32'h8143_0FFF, 32'h0000_0003, 32'h0818_78F8, 1'b0},
        {4'd5,  1'b0, 32'h80F0_0F01, 32'h0000_0004, 32'h080F_0000, 1'b0},
        {4'd6,  1'b1, 32'h1234_8001, 32'h0000_0004, 32'h2340_0010, 1'b0},
        {4'd7,  1'b0, 32'h8000_7FF0, 32'h0000_0004, 32'hF800_07FF, 1'b0},
        {4'd8,  1'b0, 32'h4000_C000, 32'h4000_4000, 32'h2000_E000, 1'b0},
        {4'd8,  1'b0, 32'h8000_8000, 32'h8000_7FFF, 32'h7FFF_8001, 1'b1},
        {4'd9,  1'b0, 32'h4000_0000, 32'hC000_0000, 32'hE000_0000, 1'b0},
        {4'd9,  1'b0, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1}
    };

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd8: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic s, input logic [31:0] x,
                       input logic [31:0] y, input logic [1:0] sel, input logic c);
        @(negedge clk);
        op = o; sat_mode = s; opnd_a = x; opnd_b = y; acc_sel = sel;
        ovf_clr = c; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic clr_only();
        @(negedge clk);
        ovf_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    task automatic chk_acc(input string tag, input logic [1:0] sel,
                           input logic [31:0] hi, input logic [31:0] lo);
        run(4'd14, 1'b0, '0, '0, sel, 1'b0);
        chk32(tag, res, lo);
        run(4'd15, 1'b0, '0, '0, sel, 1'b0);
        chk32(tag, res, hi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk32("R1", res, 32'h0);
        chk1("R1", res_valid, 1'b0);
        chk1("R1", ovf_sticky, 1'b0);
        for (int k = 0; k < 4; k++) chk_acc("R1", 2'(k), 32'h0, 32'h0);

        // table walk; ovf_clr with each op shows only that op's overflow (R12)
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][101:98], VEC[i][97], VEC[i][96:65], VEC[i][64:33], 2'd0, 1'b1);
            chk1("R2", res_valid, 1'b1);
            chk32(tag_of(VEC[i][101:98]), res, VEC[i][32:1]);
            chk1(tag_of(VEC[i][101:98]), ovf_sticky, VEC[i][0]);
        end

        // R2: idle cycle drops valid and holds result
        @(negedge clk);
        chk1("R2", res_valid, 1'b0);
        chk32("R2", res, 32'h7FFF_FFFF);

        // R12: sticky persists across a clean op, then clears alone
        chk1("R12", ovf_sticky, 1'b1);
        run(4'd0, 1'b0, 32'h1, 32'h1, 2'd0, 1'b0);
        chk32("R3", res, 32'h2);
        chk1("R12", ovf_sticky, 1'b1);
        clr_only();
        chk1("R12", ovf_sticky, 1'b0);

        // R8 / R11: Q15 accumulate into acc1
        keep = res;
        run(4'd10, 1'b1, 32'h0000_4000, 32'h0000_2000, 2'd1, 1'b0);
        chk32("R11", res, keep);
        chk1("R8", ovf_sticky, 1'b0);
        chk_acc("R8", 2'd1, 32'h0, 32'h1000_0000);
        run(4'd11, 1'b1, 32'h0000_8000, 32'h0000_8000, 2'd1, 1'b1);
        chk1("R12", ovf_sticky, 1'b1);
        chk_acc("R8", 2'd1, 32'hFFFF_FFFF, 32'h9000_0001);

        // R9 / R10: Q31 accumulate with clamp at positive limit
        clr_only();
        run(4'd12, 1'b1, 32'h8000_0000, 32'h8000_0000, 2'd2, 1'b0);
        chk1("R9", ovf_sticky, 1'b1);
        chk_acc("R9", 2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        clr_only();
        run(4'd12, 1'b1, 32'h4000_0000, 32'h4000_0000, 2'd2, 1'b0);
        chk1("R10", ovf_sticky, 1'b1);
        chk_acc("R10", 2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);

        // R10: wrap mode on acc3
        run(4'd12, 1'b0, 32'h8000_0000, 32'h8000_0000, 2'd3, 1'b1);
        chk1("R9", ovf_sticky, 1'b1);
        run(4'd12, 1'b0, 32'h4000_0000, 32'h4000_0000, 2'd3, 1'b1);
        chk1("R10", ovf_sticky, 1'b0);
        chk_acc("R10", 2'd3, 32'h9FFF_FFFF, 32'hFFFF_FFFF);

        // R9 / R10: subtract to the negative limit on acc0
        run(4'd13, 1'b1, 32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1);
        chk1("R9", ovf_sticky, 1'b1);
        chk_acc("R9", 2'd0, 32'h8000_0000, 32'h0000_0001);
        run(4'd13, 1'b1, 32'h4000_0000, 32'h4000_0000, 2'd0, 1'b1);
        chk1("R10", ovf_sticky, 1'b1);
        chk_acc("R11", 2'd0, 32'h8000_0000, 32'h0000_0000);

        // R13: operands and opcode with in_valid low do nothing
        clr_only();
        keep = res;
        @(negedge clk);
        op = 4'd12; sat_mode = 1'b1; opnd_a = 32'h8000_0000; opnd_b = 32'h8000_0000;
        acc_sel = 2'd0;
        @(negedge clk);
        op = 4'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
        @(negedge clk);
        chk1("R13", res_valid, 1'b0);
        chk32("R13", res, keep);
        chk1("R13", ovf_sticky, 1'b0);
        chk_acc("R13", 2'd0, 32'h8000_0000, 32'h0000_0000);

        // R1: reset mid-run clears flag, result and accumulators
        run(4'd8, 1'b0, 32'h8000_8000, 32'h8000_8000, 2'd0, 1'b0);
        chk1("R6", ovf_sticky, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk32("R1", res, 32'h0);
        chk1("R1", ovf_sticky, 1'b0);
        chk_acc("R1", 2'd2, 32'h0, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule